// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel. Settings are presented on configuration inputs and captured by a one-cycle load strobe, which also arms the channel. The settings are: a 24-bit memory address, a 16-bit device address, a transfer count, a counting mode, the unit size, the step direction, the addressing style and which side is the source. Each request pulse then moves exactly one byte or one word over a bus-master port.

In dual-address style, each unit takes a read cycle followed by a write cycle. The device side is addressed by placing the 16-bit device address inside a fixed upper page of the 24-bit space. In single-address style, each unit takes one bus cycle at the memory address. An acknowledge strobe selects the device instead of a device address.

There are three counting modes:
- Sequential: the memory address steps once per unit.
- Fixed: the memory address never moves.
- Repeat: after a short programmed run, the memory address and the count return to their loaded values and the channel carries on.

The bus port follows valid/ready rules. Once `bus_valid` is raised, the address, direction, size, acknowledge and write data stay unchanged until the cycle in which `bus_ready` is sampled high. That cycle is the handshake. The responder may hold `bus_ready` low for any number of cycles, and the channel simply waits. Read data is taken on the handshake edge of a read cycle.

Top module: `dma_chan`

## Requirements
- R1: After reset, `bus_valid`, `dack`, `active` and `done` are all 0.
- R2: Each accepted request makes one unit transfer. `bus_word`=1 marks a 16-bit unit and 0 an 8-bit unit. A byte read delivers its data in bits 7:0. A byte write drives `bus_wdata` bits 15:8 as zero.
- R3: In dual-address style (`cfg_single`=0), a unit is a read handshake followed directly by a write handshake, and the write data equals the data read. With `cfg_io_src`=1 the read is at the device address and the write is at the memory address; with `cfg_io_src`=0 the order is reversed. The device address on the bus is {8'hFF, device address}.
- R4: In sequential mode (`cfg_mode`=0), the memory address used by unit k is the loaded address plus k·s, where s is 1 for bytes and 2 for words. When `cfg_dec`=1 it is minus k·s instead. The result wraps within 24 bits.
- R5: In fixed mode (`cfg_mode`=1), every unit uses the loaded memory address.
- R6: In sequential and fixed modes, the count is the full 16-bit `cfg_count`, and 0 stands for 65536 units. One cycle after the write handshake of the last unit, `active` falls and `done` is high for exactly one cycle. Requests that arrive after that produce no bus cycles.
- R7: In repeat mode (`cfg_mode`=2), the run length N is `cfg_count[7:0]`, and 0 stands for 256. Unit k uses the address of unit (k mod N), stepped as in R4. `active` stays 1 and `done` stays 0 indefinitely.
- R8: In single-address style (`cfg_single`=1), each unit is one handshake at the memory address with `dack`=1. `bus_write` equals `cfg_io_src`. `dack` is 0 in every dual-address cycle.
- R9: For a word unit, bit 0 of the memory address on the bus is 0.
- R10: While `bus_valid` is 1 and `bus_ready` is 0, the next cycle keeps `bus_valid` at 1 with the same `bus_addr` and `bus_write`.
- R11: A request pulse that arrives while a unit is in progress is held, and it is served after that unit's final handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Captures all cfg_* settings and arms the channel |
| cfg_mem_addr | input | 24 | Memory-side start address |
| cfg_io_addr | input | 16 | Device-side address (dual-address style) |
| cfg_count | input | 16 | Unit count (repeat mode uses bits 7:0) |
| cfg_mode | input | 2 | 0 sequential, 1 fixed, 2 repeat |
| cfg_word | input | 1 | 1 word units, 0 byte units |
| cfg_dec | input | 1 | 1 memory address decrements |
| cfg_single | input | 1 | 1 single-address style |
| cfg_io_src | input | 1 | 1 device is the data source |
| req | input | 1 | Transfer request pulse |
| bus_valid | output | 1 | Bus cycle requested |
| bus_ready | input | 1 | Responder accepts the cycle |
| bus_addr | output | 24 | Bus address |
| bus_write | output | 1 | 1 write, 0 read |
| bus_word | output | 1 | Cycle size, 1 word |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, taken at the handshake |
| dack | output | 1 | Device acknowledge for single-address cycles |
| active | output | 1 | Channel armed |
| done | output | 1 | One-cycle end-of-count pulse |

## Verification
A request sampled high at a clock edge raises `bus_valid` on the next cycle. Each bus cycle finishes at its handshake edge, and a write cycle follows its read cycle with no gap. `done` and the fall of `active` appear one cycle after the last write handshake. A held request starts one idle cycle later. The bench drives inputs and samples outputs on the falling edge, logs every handshake, and waits for three quiet cycles before it compares the log against addresses and data computed from the settings. Flag checks are likewise taken only after those quiet cycles.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    MODE_SEQ  = 2'd0,
    MODE_FIX  = 2'd1,
    MODE_RPT  = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_ONE  = 2'd3
  } state_e;
endpackage

// File: rtl/dma_tcount.sv
module dma_tcount #(
  parameter int CW  = 16,
  parameter int RCW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          cfg_rpt,
  input  logic [CW-1:0] cfg_cnt,
  input  logic          step,
  output logic          last
);
  localparam int TW = CW + 1;

  logic [TW-1:0] left_q, init_q, init_d;
  logic          rpt_q;

  always_comb begin
    if (cfg_rpt)
      init_d = (cfg_cnt[RCW-1:0] == '0) ? (TW'(1) << RCW) : TW'(cfg_cnt[RCW-1:0]);
    else
      init_d = (cfg_cnt == '0) ? (TW'(1) << CW) : TW'(cfg_cnt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
      init_q <= '0;
      rpt_q  <= 1'b0;
    end else if (load) begin
      left_q <= init_d;
      init_q <= init_d;
      rpt_q  <= cfg_rpt;
    end else if (step) begin
      if (left_q == TW'(1))
        left_q <= rpt_q ? init_q : '0;
      else
        left_q <= left_q - TW'(1);
    end
  end

  assign last = (left_q == TW'(1));
endmodule

// File: rtl/dma_maddr.sv
module dma_maddr #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] cfg_addr,
  input  logic          step,
  input  logic          move,
  input  logic          reload,
  input  logic          word,
  input  logic          dec,
  output logic [AW-1:0] cur
);
  logic [AW-1:0] base_q, cur_q, inc;

  assign inc = word ? AW'(2) : AW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (load) begin
      base_q <= cfg_addr;
      cur_q  <= cfg_addr;
    end else if (step) begin
      if (reload)
        cur_q <= base_q;
      else if (move)
        cur_q <= dec ? cur_q - inc : cur_q + inc;
    end
  end

  assign cur = cur_q;
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int AW  = 24,
  parameter int IOW = 16,
  parameter int DW  = 16,
  parameter int CW  = 16,
  parameter int RCW = 8,
  parameter logic [AW-IOW-1:0] IO_PAGE = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_load,
  input  logic [AW-1:0]  cfg_mem_addr,
  input  logic [IOW-1:0] cfg_io_addr,
  input  logic [CW-1:0]  cfg_count,
  input  logic [1:0]     cfg_mode,
  input  logic           cfg_word,
  input  logic           cfg_dec,
  input  logic           cfg_single,
  input  logic           cfg_io_src,
  input  logic           req,
  output logic           bus_valid,
  input  logic           bus_ready,
  output logic [AW-1:0]  bus_addr,
  output logic           bus_write,
  output logic           bus_word,
  output logic [DW-1:0]  bus_wdata,
  input  logic [DW-1:0]  bus_rdata,
  output logic           dack,
  output logic           active,
  output logic           done
);
  localparam int BW = DW / 2;

  mode_e          mode_q;
  state_e         st_q;
  logic           word_q, dec_q, single_q, io_src_q;
  logic [IOW-1:0] io_q;
  logic           en_q, pend_q, done_q;
  logic [DW-1:0]  buf_q;
  logic [AW-1:0]  mem_cur, mem_a, io_full;
  logic           hs, xfer_end, start, last, is_rpt;

  assign hs       = bus_valid & bus_ready;
  assign xfer_end = hs & ((st_q == ST_WR) | (st_q == ST_ONE));
  assign start    = en_q & (st_q == ST_IDLE) & (pend_q | req);
  assign is_rpt   = (mode_q == MODE_RPT);

  dma_tcount #(.CW(CW), .RCW(RCW)) cnt_i (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .cfg_rpt(cfg_mode == MODE_RPT), .cfg_cnt(cfg_count),
    .step(xfer_end), .last(last)
  );

  dma_maddr #(.AW(AW)) addr_i (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .cfg_addr(cfg_mem_addr),
    .step(xfer_end), .move(mode_q != MODE_FIX), .reload(is_rpt & last),
    .word(word_q), .dec(dec_q), .cur(mem_cur)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= MODE_SEQ;
      word_q   <= 1'b0;
      dec_q    <= 1'b0;
      single_q <= 1'b0;
      io_src_q <= 1'b0;
      io_q     <= '0;
      en_q     <= 1'b0;
      pend_q   <= 1'b0;
      done_q   <= 1'b0;
      st_q     <= ST_IDLE;
      buf_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (cfg_load) begin
        mode_q   <= mode_e'(cfg_mode);
        word_q   <= cfg_word;
        dec_q    <= cfg_dec;
        single_q <= cfg_single;
        io_src_q <= cfg_io_src;
        io_q     <= cfg_io_addr;
        en_q     <= 1'b1;
        pend_q   <= 1'b0;
        st_q     <= ST_IDLE;
      end else begin
        if (start)
          pend_q <= pend_q & req;
        else if (req & en_q)
          pend_q <= 1'b1;

        if (xfer_end & last & !is_rpt) begin
          en_q   <= 1'b0;
          done_q <= 1'b1;
        end

        case (st_q)
          ST_IDLE: if (start) st_q <= single_q ? ST_ONE : ST_RD;
          ST_RD: if (hs) begin
            buf_q <= word_q ? bus_rdata : {{(DW-BW){1'b0}}, bus_rdata[BW-1:0]};
            st_q  <= ST_WR;
          end
          default: if (hs) st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign io_full = {IO_PAGE, io_q};
  assign mem_a   = word_q ? {mem_cur[AW-1:1], 1'b0} : mem_cur;

  always_comb begin
    bus_addr  = '0;
    bus_write = 1'b0;
    bus_wdata = '0;
    dack      = 1'b0;
    case (st_q)
      ST_RD: bus_addr = io_src_q ? io_full : mem_a;
      ST_WR: begin
        bus_addr  = io_src_q ? mem_a : io_full;
        bus_write = 1'b1;
        bus_wdata = buf_q;
      end
      ST_ONE: begin
        bus_addr  = mem_a;
        bus_write = io_src_q;
        dack      = 1'b1;
      end
      default: ;
    endcase
  end

  assign bus_valid = (st_q != ST_IDLE);
  assign bus_word  = word_q;
  assign active    = en_q;
  assign done      = done_q;
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_load,
  input logic          bus_valid,
  input logic          bus_ready,
  input logic [AW-1:0] bus_addr,
  input logic          bus_write,
  input logic          bus_word,
  input logic          dack,
  input logic          active,
  input logic          done
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready && !cfg_load |=> bus_valid && $stable(bus_addr) && $stable(bus_write));

  p_even_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_word && dack |-> !bus_addr[0]);

  p_dack_in_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> bus_valid);

  p_done_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !active);

  p_quiet_after_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !active && !bus_valid && !cfg_load |=> !bus_valid);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind dma_chan dma_chan_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .bus_valid(bus_valid),
  .bus_ready(bus_ready), .bus_addr(bus_addr), .bus_write(bus_write),
  .bus_word(bus_word), .dack(dack), .active(active), .done(done)
);

// File: tb/dma_chan_tb_top.sv
`timescale 1ns/1ps
module dma_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [23:0] cfg_mem_addr = '0;
  logic [15:0] cfg_io_addr = '0;
  logic [15:0] cfg_count = '0;
  logic [1:0]  cfg_mode = '0;
  logic        cfg_word = 1'b0, cfg_dec = 1'b0, cfg_single = 1'b0, cfg_io_src = 1'b0;
  logic        req = 1'b0;
  logic        bus_valid, bus_ready = 1'b0;
  logic [23:0] bus_addr;
  logic        bus_write, bus_word, dack, active, done;
  logic [15:0] bus_wdata, bus_rdata;

  int total = 0, bad = 0, done_cnt = 0, nlog = 0;
  logic [23:0] lg_addr [0:1023];
  logic        lg_wr [0:1023], lg_word [0:1023], lg_dack [0:1023];
  logic [15:0] lg_wdata [0:1023];

  always #2.5 clk = ~clk;

  dma_chan dut_i (.*);

  function automatic logic [15:0] rd_model(input logic [23:0] a);
    return {a[7:0] ^ 8'h3C, a[15:8] + 8'h11};
  endfunction

  assign bus_rdata = rd_model(bus_addr);

  always @(negedge clk) begin
    bus_ready <= ($urandom % 4) != 0;
    if (done) done_cnt++;
  end

  always @(posedge clk) begin
    if (bus_valid && bus_ready && nlog < 1024) begin
      lg_addr[nlog] <= bus_addr;  lg_wr[nlog] <= bus_write;
      lg_word[nlog] <= bus_word;  lg_dack[nlog] <= dack;
      lg_wdata[nlog] <= bus_wdata;
      nlog <= nlog + 1;
    end
  end

  initial begin
    #(5.0 * 190000);
    bad++; total++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic configure(input logic [1:0] m, input logic w, input logic d,
                           input logic s, input logic src, input logic [23:0] ma,
                           input logic [15:0] ia, input logic [15:0] c);
    @(negedge clk);
    cfg_mode = m; cfg_word = w; cfg_dec = d; cfg_single = s; cfg_io_src = src;
    cfg_mem_addr = ma; cfg_io_addr = ia; cfg_count = c; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    nlog = 0; done_cnt = 0;
  endtask

  task automatic pulse_req();
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 3) begin
      @(negedge clk);
      if (bus_valid) q = 0; else q++;
    end
  endtask

  function automatic logic [23:0] exp_mem(input int k);
    int n;
    int kk;
    logic [23:0] off, a;
    n  = (cfg_mode == 2) ? ((cfg_count[7:0] == 0) ? 256 : int'(cfg_count[7:0])) : 0;
    kk = (cfg_mode == 2) ? (k % n) : k;
    off = (cfg_mode == 1) ? 24'd0 : 24'(kk * (cfg_word ? 2 : 1));
    a = cfg_dec ? cfg_mem_addr - off : cfg_mem_addr + off;
    if (cfg_word) a[0] = 1'b0;
    return a;
  endfunction

  task automatic check_log(input int nx, input string tag);
    logic [23:0] io_full, rd_a, wr_a;
    logic [15:0] d;
    int per;
    io_full = {8'hFF, cfg_io_addr};
    per = cfg_single ? 1 : 2;
    chk({tag, " R2 handshake count"}, 64'(nlog), 64'(nx * per));
    for (int k = 0; k < nx && (k * per + per - 1) < nlog; k++) begin
      if (cfg_single) begin
        chk({tag, " R8 single cycle"},
            {lg_addr[k], lg_wr[k], lg_dack[k], lg_word[k]},
            {exp_mem(k), cfg_io_src, 1'b1, cfg_word});
      end else begin
        rd_a = cfg_io_src ? io_full : exp_mem(k);
        wr_a = cfg_io_src ? exp_mem(k) : io_full;
        d = rd_model(rd_a);
        if (!cfg_word) d[15:8] = 8'h00;
        chk({tag, " R3 read cycle"},
            {lg_addr[2*k], lg_wr[2*k], lg_dack[2*k], lg_word[2*k]},
            {rd_a, 1'b0, 1'b0, cfg_word});
        chk({tag, " R3 R2 write cycle"},
            {lg_addr[2*k+1], lg_wr[2*k+1], lg_dack[2*k+1], lg_wdata[2*k+1]},
            {wr_a, 1'b1, 1'b0, d});
      end
    end
  endtask

  task automatic run_case(input logic [1:0] m, input logic w, input logic d,
                          input logic s, input logic src, input logic [23:0] ma,
                          input logic [15:0] ia, input logic [15:0] c, input int n,
                          input string tag);
    int lim, nx;
    bit fin;
    configure(m, w, d, s, src, ma, ia, c);
    for (int i = 0; i < n; i++) begin
      pulse_req();
      wait_quiet();
    end
    lim = (c == 0) ? 65536 : int'(c);
    fin = (m != 2) && (n >= lim);
    nx = fin ? lim : n;
    check_log(nx, tag);
    chk({tag, " R6 R7 done count"}, 64'(done_cnt), fin ? 64'd1 : 64'd0);
    chk({tag, " R6 R7 active"}, 64'(active), fin ? 64'd0 : 64'd1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {60'd0, bus_valid, dack, active, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run_case(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 24'h00_1000, 16'h0040, 16'd3, 5, "seq byte up R4");
    run_case(2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 24'h00_0001, 16'h1234, 16'd4, 4, "seq word down wrap R4 R9");
    run_case(2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 24'hAB_CDE3, 16'h0000, 16'd2, 3, "fixed single R5 R8 R9");
    run_case(2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 24'hFF_FFFE, 16'h0000, 16'h0703, 8, "repeat wrap R7");
    run_case(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 24'h00_2000, 16'h0001, 16'd0, 3, "count zero R6");
    run_case(2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 24'h12_0000, 16'h8000, 16'h0100, 258, "repeat 256 R7");

    configure(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 24'h00_3000, 16'h0010, 16'd10);
    pulse_req();
    pulse_req();
    wait_quiet();
    check_log(2, "pending R11");
    chk("R11 still active", 64'(active), 64'd1);

    for (int it = 0; it < 30; it++) begin
      logic [1:0] m;
      logic [15:0] c;
      m = 2'($urandom % 3);
      c = 16'(1 + $urandom % 6);
      if (m == 2 && ($urandom % 2) == 1) c = c | 16'h5500;
      run_case(m, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               24'($urandom), 16'($urandom), c, 1 + int'($urandom % 8),
               "random R2 R3 R4 R5 R6 R7 R8");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule